// File: doc/BRIEF.md
# Lane Burst Receiver Aligner

This block sits on one data lane of a serial link, after the deserializer. It watches the two single-ended line levels used at low power. High-speed capture starts only after the lane has moved from the stop level through the request level to the prepare level, in that order. The two-bit-per-cycle double-data-rate stream then feeds a sliding window. The window skips the zero preamble and looks for the sync byte 0xB8 at every bit offset. Once the sync byte is found, byte alignment is fixed for the rest of the burst.

After lock the receiver assembles payload bytes least-significant bit first. Each byte comes out with a one-cycle valid strobe. The first byte of a burst carries a start flag and the last complete byte carries an end flag. The burst ends when the line levels settle back at the stop level, and any bits that do not fill a whole byte are dropped. A sync byte with one wrong bit raises an error flag. So does a search that runs past a bit budget. In both cases the receiver does not lock on the bad match.

Top module: `lane_burst_rx`

## Requirements
- R1: After reset `valid_o`, `start_o`, `end_o` and `err_o` are low, and the accepted line level is stop (both lines high).
- R2: The line levels are read as {`lp_p_i`,`lp_n_i`}: 11 is stop, 00 is request, 01 is prepare. Capture arms only on the accepted sequence 11, then 00, then 01. A lane that leaves stop through any other level (for example 11 to 01, or 11 to 10) is ignored until it returns to 11, and no bytes are produced.
- R3: Each line passes a two-flop synchronizer. A level is accepted only after it has stayed unchanged for `STABLE_CYC` synchronized cycles, so a stop-level pulse shorter than that inside a burst does not end the burst.
- R4: While searching, the first bit of each cycle is `hs_bits_i[0]` and the second is `hs_bits_i[1]`. The receiver locks on the first 8-bit window, at any bit offset, equal to the pattern 0,0,0,1,1,1,0,1 in arrival order (0xB8 read LSB first) whose preceding bit is 0. Leading zeros are skipped.
- R5: After lock, each group of 8 bits is output on `byte_o` with arrival bit 0 in byte bit 0. Every byte is marked by a one-cycle `valid_o` pulse, in arrival order.
- R6: `start_o` is high together with `valid_o` for the first byte of each burst and at no other time.
- R7: When the stop level is accepted during a locked burst, the partial byte is discarded. The last complete byte is output with `end_o` high.
- R8: A window with exactly one bit differing from the sync pattern (preceding bit 0) sets `err_o` and does not lock. The search continues, and a later exact sync still locks.
- R9: If no sync is found within `SYNC_TIMEOUT` searched bits, `err_o` is set. The lane stream is then ignored, including a later sync, until the stop level returns.
- R10: `err_o` holds its value until the next burst arms, and is cleared at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Deserialized stream clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lp_p_i | input | 1 | Positive line level at low power (asynchronous) |
| lp_n_i | input | 1 | Negative line level at low power (asynchronous) |
| hs_bits_i | input | 2 | Two received bits per cycle, bit 0 earlier |
| byte_o | output | 8 | Aligned payload byte |
| valid_o | output | 1 | One-cycle strobe for `byte_o` |
| start_o | output | 1 | First byte of the burst |
| end_o | output | 1 | Last complete byte of the burst |
| err_o | output | 1 | Near-miss sync or sync timeout since last arm |

## Verification
Bursts are sent with an even preamble, an odd preamble and no preamble. Between them these place the sync byte at both bit offsets a cycle can hold, which shows whether the window tests every offset and carries the leftover bit into the first byte. Payloads of zero, one and several bytes show whether the start and end flags fall on the right bytes and whether the trailing part-byte is dropped. A one-bit-wrong sync followed by the true sync, a preamble longer than the bit budget, a short stop pulse inside a burst, and two wrong entry orders each check one rule: the error flag, the give-up path, the level filter, and the entry order.

// File: rtl/lane_rx_pkg.sv
package lane_rx_pkg;
  localparam int LANE_W = 2;
  localparam logic [7:0] SYNC_PAT = 8'hB8;

  // {p, n} line levels
  typedef enum logic [1:0] {
    LP_00 = 2'b00,
    LP_01 = 2'b01,
    LP_10 = 2'b10,
    LP_11 = 2'b11
  } lp_lvl_e;

  typedef enum logic [2:0] {
    ST_STOP,
    ST_REQ,
    ST_IGNORE,
    ST_SEARCH,
    ST_LOCK,
    ST_WAIT
  } rx_st_e;
endpackage

// File: rtl/lp_level_filter.sv
module lp_level_filter
  import lane_rx_pkg::*;
#(
  parameter int STABLE_CYC = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    lp_p_i,
  input  logic    lp_n_i,
  output lp_lvl_e lvl_o
);
  localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;

  logic [1:0]    s1_q, s2_q, cand_q;
  logic [CW-1:0] cnt_q;
  lp_lvl_e       lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 2'b11;
      s2_q   <= 2'b11;
      cand_q <= 2'b11;
      cnt_q  <= '0;
      lvl_q  <= LP_11;
    end else begin
      s1_q <= {lp_p_i, lp_n_i};
      s2_q <= s1_q;
      if (s2_q != cand_q) begin
        cand_q <= s2_q;
        cnt_q  <= '0;
      end else if (cnt_q != CW'(STABLE_CYC - 1)) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        lvl_q <= lp_lvl_e'(cand_q);
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import lane_rx_pkg::*;
#(
  parameter int SYNC_TIMEOUT = 256
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  lp_lvl_e lvl_i,
  input  logic    hit_i,
  input  logic    miss1_i,
  output rx_st_e  st_o,
  output logic    arm_o,
  output logic    hunt_o,
  output logic    lock_go_o,
  output logic    run_o,
  output logic    flush_o,
  output logic    err_o
);
  localparam int BW = $clog2(SYNC_TIMEOUT + LANE_W + 1);

  rx_st_e        st_q, st_d;
  logic [BW-1:0] bcnt_q;
  logic          err_q;
  logic          stop, tmo;

  assign stop      = (lvl_i == LP_11);
  assign tmo       = (bcnt_q + BW'(LANE_W)) >= BW'(SYNC_TIMEOUT);
  assign arm_o     = (st_q == ST_REQ) && (lvl_i == LP_01);
  assign hunt_o    = (st_q == ST_SEARCH) && !stop;
  assign lock_go_o = hunt_o && hit_i;
  assign run_o     = (st_q == ST_LOCK) && !stop;
  assign flush_o   = (st_q == ST_LOCK) && stop;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_STOP: begin
        if (lvl_i == LP_00) st_d = ST_REQ;
        else if (!stop)     st_d = ST_IGNORE;
      end
      ST_REQ: begin
        if (lvl_i == LP_01)      st_d = ST_SEARCH;
        else if (lvl_i == LP_10) st_d = ST_IGNORE;
        else if (stop)           st_d = ST_STOP;
      end
      ST_SEARCH: begin
        if (stop)       st_d = ST_STOP;
        else if (hit_i) st_d = ST_LOCK;
        else if (tmo)   st_d = ST_WAIT;
      end
      ST_IGNORE, ST_LOCK, ST_WAIT: begin
        if (stop) st_d = ST_STOP;
      end
      default: st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_STOP;
      bcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (arm_o) begin
        bcnt_q <= '0;
        err_q  <= 1'b0;
      end else if (hunt_o) begin
        bcnt_q <= bcnt_q + BW'(LANE_W);
        if (!hit_i && (miss1_i || tmo)) err_q <= 1'b1;
      end
    end
  end

  assign st_o  = st_q;
  assign err_o = err_q;
endmodule

// File: rtl/sync_hunter.sv
module sync_hunter
  import lane_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [LANE_W-1:0] bits_i,
  output logic              hit_o,
  output logic              miss1_o,
  output logic [LANE_W-1:0] carry_o,
  output logic [2:0]        carry_n_o
);
  localparam int WIN = LANE_W + 8;

  logic [WIN-1:0]    win_q, win_nxt;
  logic [LANE_W-1:0] m, n1;
  logic [LANE_W-1:0] cr [LANE_W];
  logic              any_hit;

  // oldest bit at index 0
  assign win_nxt = {bits_i, win_q[WIN-1:LANE_W]};

  for (genvar g = 0; g < LANE_W; g++) begin : g_off
    localparam int OFF = g + 1;
    logic [7:0] diff;
    assign diff  = win_nxt[OFF+7:OFF] ^ SYNC_PAT;
    assign m[g]  = (diff == 8'h00) && !win_nxt[OFF-1];
    assign n1[g] = ($countones(diff) == 1) && !win_nxt[OFF-1];
    assign cr[g] = LANE_W'(win_nxt >> (OFF + 8));
  end

  // lowest offset (oldest alignment) wins
  always_comb begin
    any_hit   = 1'b0;
    carry_o   = '0;
    carry_n_o = '0;
    for (int i = LANE_W - 1; i >= 0; i--) begin
      if (m[i]) begin
        any_hit   = 1'b1;
        carry_o   = cr[i];
        carry_n_o = 3'(LANE_W - 1 - i);
      end
    end
  end

  assign hit_o   = en_i && any_hit;
  assign miss1_o = en_i && (|n1) && !any_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (clear_i) win_q <= '0;
    else if (en_i)    win_q <= win_nxt;
  end
endmodule

// File: rtl/byte_packer.sv
module byte_packer
  import lane_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LANE_W-1:0] carry_i,
  input  logic [2:0]        carry_n_i,
  input  logic              run_i,
  input  logic              flush_i,
  input  logic [LANE_W-1:0] bits_i,
  output logic [7:0]        byte_o,
  output logic              valid_o,
  output logic              start_o,
  output logic              end_o
);
  localparam int TW = 8 + LANE_W;

  logic [7:0]    acc_q, pend_q, byte_q;
  logic [2:0]    cnt_q;
  logic          pend_v_q, first_q, valid_q, start_q, end_q;
  logic [TW-1:0] tmp;
  logic [3:0]    tmp_n;
  logic          full;

  assign tmp   = {{LANE_W{1'b0}}, acc_q} | (TW'(bits_i) << cnt_q);
  assign tmp_n = {1'b0, cnt_q} + 4'(LANE_W);
  assign full  = tmp_n[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      first_q  <= 1'b0;
      byte_q   <= '0;
      valid_q  <= 1'b0;
      start_q  <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      if (load_i) begin
        acc_q    <= {{(8-LANE_W){1'b0}}, carry_i};
        cnt_q    <= carry_n_i;
        pend_v_q <= 1'b0;
        first_q  <= 1'b1;
      end else if (run_i) begin
        cnt_q <= tmp_n[2:0];
        if (full) begin
          acc_q    <= 8'(tmp >> 8);
          pend_q   <= tmp[7:0];
          pend_v_q <= 1'b1;
          // one byte held back so the last can be tagged
          if (pend_v_q) begin
            valid_q <= 1'b1;
            byte_q  <= pend_q;
            start_q <= first_q;
            first_q <= 1'b0;
          end
        end else begin
          acc_q <= tmp[7:0];
        end
      end else if (flush_i) begin
        acc_q    <= '0;
        cnt_q    <= '0;
        pend_v_q <= 1'b0;
        if (pend_v_q) begin
          valid_q <= 1'b1;
          byte_q  <= pend_q;
          start_q <= first_q;
          end_q   <= 1'b1;
          first_q <= 1'b0;
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;
  assign start_o = start_q;
  assign end_o   = end_q;
endmodule

// File: rtl/lane_burst_rx.sv
module lane_burst_rx
  import lane_rx_pkg::*;
#(
  parameter int STABLE_CYC   = 4,
  parameter int SYNC_TIMEOUT = 256
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   lp_p_i,
  input  logic                   lp_n_i,
  input  logic [LANE_W-1:0]      hs_bits_i,
  output logic [7:0]             byte_o,
  output logic                   valid_o,
  output logic                   start_o,
  output logic                   end_o,
  output logic                   err_o
);
  lp_lvl_e           lvl;
  rx_st_e            st;
  logic              arm, hunt, lock_go, run, flush;
  logic              hit, miss1;
  logic [LANE_W-1:0] carry;
  logic [2:0]        carry_n;

  lp_level_filter #(.STABLE_CYC(STABLE_CYC)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lp_p_i (lp_p_i),
    .lp_n_i (lp_n_i),
    .lvl_o  (lvl)
  );

  burst_ctrl #(.SYNC_TIMEOUT(SYNC_TIMEOUT)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .hit_i     (hit),
    .miss1_i   (miss1),
    .st_o      (st),
    .arm_o     (arm),
    .hunt_o    (hunt),
    .lock_go_o (lock_go),
    .run_o     (run),
    .flush_o   (flush),
    .err_o     (err_o)
  );

  sync_hunter u_hunt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (arm),
    .en_i      (hunt),
    .bits_i    (hs_bits_i),
    .hit_o     (hit),
    .miss1_o   (miss1),
    .carry_o   (carry),
    .carry_n_o (carry_n)
  );

  byte_packer u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (lock_go),
    .carry_i   (carry),
    .carry_n_i (carry_n),
    .run_i     (run),
    .flush_i   (flush),
    .bits_i    (hs_bits_i),
    .byte_o    (byte_o),
    .valid_o   (valid_o),
    .start_o   (start_o),
    .end_o     (end_o)
  );
endmodule

// File: rtl/lane_burst_rx_chk.sv
module lane_burst_rx_chk
  import lane_rx_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input rx_st_e st_i,
  input logic   valid_o,
  input logic   start_o,
  input logic   end_o,
  input logic   err_o
);
  // R6
  start_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> valid_o);

  // R7
  end_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> valid_o);

  // R5
  valid_from_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(st_i) == ST_LOCK));

  // R2
  search_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i == ST_SEARCH) && ($past(st_i) != ST_SEARCH)) |-> ($past(st_i) == ST_REQ));

  // R4
  lock_after_search_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i == ST_LOCK) && ($past(st_i) != ST_LOCK)) |-> ($past(st_i) == ST_SEARCH));

  // R9
  err_rise_in_search_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(st_i) == ST_SEARCH));

  // R10
  err_clear_on_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i == ST_SEARCH) && ($past(st_i) == ST_REQ)) |-> !err_o);
endmodule

bind lane_burst_rx lane_burst_rx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .st_i    (st),
  .valid_o (valid_o),
  .start_o (start_o),
  .end_o   (end_o),
  .err_o   (err_o)
);

// File: tb/lane_burst_rx_bench.sv
module lane_burst_rx_bench;
  localparam int STABLE = 3;
  localparam int TMO    = 96;

  typedef struct packed {
    logic [7:0] b;
    logic       s;
    logic       e;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lp_p = 1'b1, lp_n = 1'b1;
  logic [1:0] hs = 2'b00;
  logic [7:0] byte_q;
  logic       valid, start, endf, err;

  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t sbq[$];
  exp_t mon_e;
  bit   bq[$];

  always #10 clk = ~clk;

  lane_burst_rx #(.STABLE_CYC(STABLE), .SYNC_TIMEOUT(TMO)) u_lane_burst_rx (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .lp_p_i    (lp_p),
    .lp_n_i    (lp_n),
    .hs_bits_i (hs),
    .byte_o    (byte_q),
    .valid_o   (valid),
    .start_o   (start),
    .end_o     (endf),
    .err_o     (err)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pl(int seed, int k);
    return 8'(seed * 29 + k * 71 + 5);
  endfunction

  // monitor: {start,end,byte} compared against scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R5", "unexpected byte", {22'd0, start, endf, byte_q}, 0);
        end else begin
          mon_e = sbq.pop_front();
          check(byte_q == mon_e.b && start == mon_e.s && endf == mon_e.e, "R5/R6/R7",
                "byte {start,end,data}", {22'd0, start, endf, byte_q},
                {22'd0, mon_e.s, mon_e.e, mon_e.b});
        end
      end else if (start || endf) begin
        check(1'b0, "R6", "flag without valid", {30'd0, start, endf}, 0);
      end
    end
  end

  task automatic lp_hold(logic p, logic n, int cyc);
    repeat (cyc) begin
      @(negedge clk);
      lp_p = p;
      lp_n = n;
      hs   = 2'b00;
    end
  endtask

  // mode 0: 11,00,01   mode 1: 11,01   mode 2: 11,10,00,01
  task automatic enter(int mode);
    lp_hold(1, 1, 8);
    if (mode == 2) lp_hold(1, 0, 8);
    if (mode != 1) lp_hold(0, 0, 8);
    lp_hold(0, 1, 8);
  endtask

  task automatic push_byte(logic [7:0] v);
    for (int j = 0; j < 8; j++) bq.push_back(v[j]);
  endtask

  task automatic burst(int mode, int pre, bit near, int nb, int seed, int glitch_at,
                       bit expect_lock, bit exp_err, string tag);
    enter(mode);
    bq.delete();
    for (int j = 0; j < pre; j++) bq.push_back(1'b0);
    if (near) begin
      push_byte(8'h38);
      push_byte(8'h00);
    end
    push_byte(8'hB8);
    for (int k = 0; k < nb; k++) push_byte(pl(seed, k));
    if (bq.size() % 2 != 0) bq.push_back(1'b0);
    if (expect_lock) begin
      for (int k = 0; k < nb; k++) sbq.push_back('{b: pl(seed, k), s: (k == 0), e: 1'b0});
      // trailing zero bits fill one byte before the stop level is accepted
      sbq.push_back('{b: 8'h00, s: (nb == 0), e: 1'b1});
    end
    for (int k = 0; k < bq.size(); k += 2) begin
      @(negedge clk);
      hs = {bq[k+1], bq[k]};
      if (k / 2 == glitch_at) {lp_p, lp_n} = 2'b11;
      else                    {lp_p, lp_n} = 2'b01;
    end
    lp_hold(1, 1, 14);
    check(sbq.size() == 0, tag, "bytes outstanding at burst end", sbq.size(), 0);
    sbq.delete();
    check(err == exp_err, tag, "err_o after burst", err, exp_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check({valid, start, endf, err} == 4'b0000, "R1", "outputs after reset",
          {valid, start, endf, err}, 0);

    // R4 R5: even preamble, several bytes
    burst(0, 8, 1'b0, 4, 1, -1, 1'b1, 1'b0, "R4");
    // R4: odd preamble moves sync to the other offset
    burst(0, 7, 1'b0, 5, 2, -1, 1'b1, 1'b0, "R4");
    // R4: no preamble
    burst(0, 0, 1'b0, 3, 3, -1, 1'b1, 1'b0, "R5");
    // R6 R7: single payload byte and empty payload
    burst(0, 5, 1'b0, 1, 4, -1, 1'b1, 1'b0, "R7");
    burst(0, 6, 1'b0, 0, 5, -1, 1'b1, 1'b0, "R6");
    // R3: one-cycle stop pulse mid burst
    burst(0, 8, 1'b0, 6, 6, 10, 1'b1, 1'b0, "R3");
    // R8: near-miss sync then true sync
    burst(0, 4, 1'b1, 3, 7, -1, 1'b1, 1'b1, "R8");
    // R10: next arm clears error
    burst(0, 8, 1'b0, 2, 8, -1, 1'b1, 1'b0, "R10");
    // R9: sync beyond bit budget is ignored
    burst(0, 160, 1'b0, 3, 9, -1, 1'b0, 1'b1, "R9");
    burst(0, 3, 1'b0, 2, 10, -1, 1'b1, 1'b0, "R10");
    // R2: wrong entry orders
    burst(1, 8, 1'b0, 3, 11, -1, 1'b0, 1'b0, "R2");
    burst(2, 8, 1'b0, 3, 12, -1, 1'b0, 1'b0, "R2");
    burst(0, 9, 1'b0, 4, 13, -1, 1'b1, 1'b0, "R2");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule